// File: doc/BRIEF.md
# Synthesiser Control Port over I2C

This block is the two-wire register port of a frequency-synthesiser controller. It answers to a 7-bit address of which the upper five bits are fixed and the lower two come from pins. A write transaction carries any number of byte pairs. The top bit of the first byte of each pair says whether the pair is the 15-bit divider word or the two control bytes. A read transaction returns a status byte with a power-on flag and a lock flag. The byte is repeated for as long as the master acknowledges it.

SCL and SDA are sampled into the system clock domain. START and STOP are found from SDA transitions while SCL is high. The block pulls SDA low through a single drive-enable output. The divider word is staged, so the synthesiser never sees half of a new word. A STOP that cuts a byte short leaves every register as it was. The power-on flag stays set until a read transaction has been closed by a STOP.

Top module: `tuner_ctl_i2c`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1,1,0,0,0,addr_pins[1],addr_pins[0]. Bit 0 of that byte selects the direction: 0 is write, 1 is read. Any other address gets no acknowledge, and data bytes that follow it change nothing.
- R2: In a write transaction that has been addressed, the block pulls SDA low in the acknowledge slot after every data byte.
- R3: A first byte with bit 7 = 0 is the divider high byte and carries word bits 14..8 in its bits 6..0. The next byte carries word bits 7..0. div_word changes only once the low byte has been received, and then takes all 15 bits together.
- R4: A first byte with bit 7 = 1 is control byte A. Bits 6..5 go to cp_code and bits 4..0 go to ref_code, and both update as soon as the byte has been received.
- R5: The byte after control byte A is control byte B. Bits 7..5 go to test_code, bit 4 to osc_sel, bit 3 to path_sel, bit 1 to refout_en and bit 0 to port_bit. Bit 2 has no effect.
- R6: Pairs can follow each other without a new address. Each pair is classified by the top bit of its own first byte. The second byte of a pair is never classified, even when its bit 7 is 1.
- R7: A STOP that follows a divider high byte whose low byte has not arrived loads bits 14..8 into div_word and keeps bits 7..0.
- R8: A STOP in the middle of a byte discards the partial byte. All registers keep their previous values.
- R9: A read transaction returns the status byte MSB first as {por, lock_i, 000000}. The byte is sent again after each master acknowledge. After a master no-acknowledge the block releases SDA until the next START.
- R10: The power-on flag is 1 after reset and is set again while supply_low is high. A STOP that ends a read transaction clears it.
- R11: After reset div_word, ref_code, cp_code, test_code, osc_sel, path_sel and port_bit are 0, refout_en is 1, and SDA is released.
- R12: A repeated START restarts pair tracking, so the first data byte after the new address is classified again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_pins | input | 2 | Pin-selected low address bits |
| lock_i | input | 1 | Synthesiser lock indication for the status byte |
| supply_low | input | 1 | Supply-drop detector; sets the power-on flag |
| div_word | output | 15 | Active divider word |
| ref_code | output | 5 | Reference divider ratio code |
| cp_code | output | 2 | Charge pump current code |
| test_code | output | 3 | Test mode code |
| osc_sel | output | 1 | Oscillator select |
| path_sel | output | 1 | Baseband path select |
| refout_en | output | 1 | Reference output enable |
| port_bit | output | 1 | General-purpose port state |

## Verification
The assertions run on every cycle. They check that SDA is released while the block is idle and while it waits for the master's acknowledge, and that each received data byte comes with an acknowledge drive. They also check that pair tracking toggles on every accepted byte, that div_word changes only on a byte or a STOP, and that the power-on flag clears only on a STOP that ends a read. Other behaviours can only be shown by the bench's scenarios. Among them are the staging of the divider word, STOP part-way through a pair or a byte, reclassification after a repeated START, the ignored bit of control byte B, the silence after a no-acknowledge and the status values. A behavioural model checks every output field against its expected value on every clock.

// File: rtl/tcif_pkg.sv
package tcif_pkg;
  localparam int LO_W  = 8;
  localparam int HI_W  = 7;
  localparam int DIV_W = HI_W + LO_W;
  localparam int REF_W = 5;
  localparam int CP_W  = 2;
  localparam int TM_W  = 3;
  localparam int CNT_W = 4;
  localparam logic [4:0] DEV_ID = 5'b11000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } eng_state_t;

  typedef struct packed {
    logic [TM_W-1:0] test;
    logic            osc;
    logic            path;
    logic            refout;
    logic            port;
  } ctl_b_t;
endpackage

// File: rtl/tcif_line_sync.sv
module tcif_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_sh[0] <= 1'b1;
            sda_sh[0] <= 1'b1;
          end else begin
            scl_sh[0] <= scl_in;
            sda_sh[0] <= sda_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_sh[g] <= 1'b1;
            sda_sh[g] <= 1'b1;
          end else begin
            scl_sh[g] <= scl_sh[g-1];
            sda_sh[g] <= sda_sh[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tcif_engine.sv
module tcif_engine
  import tcif_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic [1:0] addr_pins,
  input  logic [7:0] status_byte,
  output logic       sda_oe,
  output logic       byte_vld,
  output logic [7:0] byte_q,
  output logic       rd_txn
);
  eng_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh;
  logic             is_addr;
  logic             rw;
  logic             mack_ok;
  logic             addr_match;

  assign addr_match = (sh[7:1] == {DEV_ID, addr_pins});

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      is_addr  <= 1'b0;
      rw       <= 1'b0;
      mack_ok  <= 1'b0;
      sda_oe   <= 1'b0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      rd_txn   <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (start_i) begin
        state   <= ST_RX;
        is_addr <= 1'b1;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        rd_txn  <= 1'b0;
      end else if (stop_i) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise && cnt != CNT_W'(8)) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(8)) begin
              if (is_addr) begin
                if (addr_match) begin
                  state   <= ST_ACK;
                  sda_oe  <= 1'b1;
                  rw      <= sh[0];
                  rd_txn  <= sh[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                byte_vld <= 1'b1;
                byte_q   <= sh;
                sda_oe   <= 1'b1;
                state    <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt     <= '0;
              is_addr <= 1'b0;
              if (rw) begin
                state  <= ST_TX;
                sh     <= status_byte;
                sda_oe <= ~status_byte[7];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_W'(8)) begin
                state   <= ST_MACK;
                sda_oe  <= 1'b0;
                mack_ok <= 1'b0;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_ok) begin
                state  <= ST_TX;
                cnt    <= '0;
                sh     <= status_byte;
                sda_oe <= ~status_byte[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2
  ack_on_byte_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> sda_oe);
  // R9
  release_in_mack_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK) |-> !sda_oe);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/tcif_regs.sv
module tcif_regs
  import tcif_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             rd_txn_i,
  input  logic             supply_low,
  output logic [DIV_W-1:0] div_q,
  output logic [REF_W-1:0] ref_q,
  output logic [CP_W-1:0]  cp_q,
  output ctl_b_t           ctl_q,
  output logic             por_q
);
  logic            pos_q;
  logic            kind_ctl;
  logic [HI_W-1:0] hi_stage;
  logic            pend;
  logic            b2_unused;

  assign b2_unused = byte_i[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= 1'b0;
      kind_ctl <= 1'b0;
      hi_stage <= '0;
      pend     <= 1'b0;
      div_q    <= '0;
      ref_q    <= '0;
      cp_q     <= '0;
      ctl_q    <= '{test: '0, osc: 1'b0, path: 1'b0, refout: 1'b1, port: 1'b0};
    end else if (start_i) begin
      pos_q <= 1'b0;
    end else if (stop_i) begin
      pos_q <= 1'b0;
      if (pend) begin
        div_q[DIV_W-1:LO_W] <= hi_stage;
        pend                <= 1'b0;
      end
    end else if (byte_vld_i) begin
      if (!pos_q) begin
        pos_q    <= 1'b1;
        kind_ctl <= byte_i[7];
        if (byte_i[7]) begin
          cp_q  <= byte_i[6:5];
          ref_q <= byte_i[4:0];
        end else begin
          hi_stage <= byte_i[HI_W-1:0];
          pend     <= 1'b1;
        end
      end else begin
        pos_q <= 1'b0;
        if (kind_ctl) begin
          ctl_q.test   <= byte_i[7:5];
          ctl_q.osc    <= byte_i[4];
          ctl_q.path   <= byte_i[3];
          ctl_q.refout <= byte_i[1];
          ctl_q.port   <= byte_i[0];
        end else begin
          div_q <= {hi_stage, byte_i};
          pend  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      por_q <= 1'b1;
    end else if (supply_low) begin
      por_q <= 1'b1;
    end else if (stop_i && rd_txn_i) begin
      por_q <= 1'b0;
    end
  end

  // R10
  por_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(por_q) |-> $past(stop_i && rd_txn_i));
  // R6
  pair_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld_i |=> (pos_q != $past(pos_q)));
  // R3
  div_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_q) |-> $past(byte_vld_i || stop_i));
endmodule

// File: rtl/tuner_ctl_i2c.sv
module tuner_ctl_i2c
  import tcif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       addr_pins,
  input  logic             lock_i,
  input  logic             supply_low,
  output logic [DIV_W-1:0] div_word,
  output logic [REF_W-1:0] ref_code,
  output logic [CP_W-1:0]  cp_code,
  output logic [TM_W-1:0]  test_code,
  output logic             osc_sel,
  output logic             path_sel,
  output logic             refout_en,
  output logic             port_bit
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       byte_vld, rd_txn, por;
  logic [7:0] byte_q;
  ctl_b_t     ctl;

  tcif_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tcif_engine u_eng (
    .clk(clk), .rst(rst), .start_i(start_det), .stop_i(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .addr_pins(addr_pins), .status_byte({por, lock_i, 6'b0}),
    .sda_oe(sda_oe), .byte_vld(byte_vld), .byte_q(byte_q), .rd_txn(rd_txn)
  );

  tcif_regs u_regs (
    .clk(clk), .rst(rst), .start_i(start_det), .stop_i(stop_det),
    .byte_vld_i(byte_vld), .byte_i(byte_q), .rd_txn_i(rd_txn),
    .supply_low(supply_low), .div_q(div_word), .ref_q(ref_code),
    .cp_q(cp_code), .ctl_q(ctl), .por_q(por)
  );

  assign test_code = ctl.test;
  assign osc_sel   = ctl.osc;
  assign path_sel  = ctl.path;
  assign refout_en = ctl.refout;
  assign port_bit  = ctl.port;
endmodule

// File: tb/tuner_ctl_i2c_bench.sv
`timescale 1ns/1ps
module tuner_ctl_i2c_bench;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [1:0] addr_pins = 2'b10;
  logic lock_i = 1'b0, supply_low = 1'b0;
  logic [14:0] div_word;
  logic [4:0] ref_code;
  logic [1:0] cp_code;
  logic [2:0] test_code;
  logic osc_sel, path_sel, refout_en, port_bit;

  int compared = 0, mismatched = 0;
  bit settle = 1'b0, done = 1'b0;

  logic [14:0] e_div = '0;
  logic [4:0]  e_ref = '0;
  logic [1:0]  e_cp = '0;
  logic [2:0]  e_test = '0;
  logic        e_osc = 0, e_path = 0, e_re = 1, e_p0 = 0;
  logic [6:0]  m_hi = '0;
  bit          m_pend = 0, m_pos = 0, m_kind = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tuner_ctl_i2c u_tuner_ctl_i2c (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(addr_pins), .lock_i(lock_i), .supply_low(supply_low),
    .div_word(div_word), .ref_code(ref_code), .cp_code(cp_code),
    .test_code(test_code), .osc_sel(osc_sel), .path_sel(path_sel),
    .refout_en(refout_en), .port_bit(port_bit)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of all fields: R3 R4 R5 R6 R7 R8 R11 R12
  always @(negedge clk) begin
    if (!rst && !settle && !done) begin
      check({div_word, ref_code, cp_code, test_code, osc_sel, path_sel, refout_en, port_bit} ==
            {e_div, e_ref, e_cp, e_test, e_osc, e_path, e_re, e_p0},
            "R3 R4 R5 field compare",
            int'({div_word, ref_code, cp_code, test_code, osc_sel, path_sel, refout_en, port_bit}),
            int'({e_div, e_ref, e_cp, e_test, e_osc, e_path, e_re, e_p0}));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_byte(input logic [7:0] b);
    if (!m_pos) begin
      m_kind = b[7];
      if (b[7]) begin e_cp = b[6:5]; e_ref = b[4:0]; end
      else begin m_hi = b[6:0]; m_pend = 1; end
      m_pos = 1;
    end else begin
      if (m_kind) begin
        e_test = b[7:5]; e_osc = b[4]; e_path = b[3]; e_re = b[1]; e_p0 = b[0];
      end else begin
        e_div = {m_hi, b}; m_pend = 0;
      end
      m_pos = 0;
    end
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
    m_pos = 0;
  endtask

  task automatic i2c_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q);
    settle = 1; sda_m = 1; tick(2*Q);
    if (m_pend) begin e_div[14:8] = m_hi; m_pend = 0; end
    m_pos = 0; settle = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit apply, input string tag);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) settle = 1;
      put_bit(b[i]);
    end
    if (apply) m_byte(b);
    settle = 0;
    sda_m = 1; tick(Q); scl_m = 1; tick(Q);
    check((sda_line == 1'b0) == exp_ack, tag, int'(sda_line), int'(!exp_ack));
    tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1; tick(Q); got = {got[6:0], sda_line}; tick(Q); scl_m = 0; tick(Q);
    end
    sda_m = !mack; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q); sda_m = 1;
  endtask

  localparam logic [7:0] AW = 8'b1100_0100;
  localparam logic [7:0] AR = 8'b1100_0101;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] got;
    tick(5); rst = 0; tick(10);
    // R11 reset state
    check(div_word == 0, "R11 div reset", div_word, 0);
    check(refout_en == 1 && port_bit == 0, "R11 refout/port reset", {refout_en, port_bit}, 2);
    check(sda_line == 1, "R11 sda released", sda_line, 1);

    // R1 R2 R3 divider pair
    i2c_start();
    send_byte(AW, 1, 0, "R1 address ack");
    send_byte(8'h12, 1, 1, "R2 data ack");
    check(div_word == 0, "R3 word held after high byte", div_word, 0);
    send_byte(8'h34, 1, 1, "R2 data ack");
    check(div_word == 15'h1234, "R3 word applied", div_word, 15'h1234);
    i2c_stop();

    // R4 R5 control pair
    i2c_start();
    send_byte(AW, 1, 0, "R1 address ack");
    send_byte(8'b1101_0110, 1, 1, "R2 data ack");
    check(cp_code == 2 && ref_code == 5'd22, "R4 control A", {cp_code, ref_code}, {2'd2, 5'd22});
    send_byte(8'b1011_1101, 1, 1, "R2 data ack");
    check({test_code, osc_sel, path_sel, refout_en, port_bit} == 7'b101_1_1_0_1,
          "R5 control B bit2 ignored", {test_code, osc_sel, path_sel, refout_en, port_bit}, 7'b1011101);
    i2c_stop();

    // R6 several pairs, low byte with msb set
    i2c_start();
    send_byte(AW, 1, 0, "R1 address ack");
    send_byte(8'h7F, 1, 1, "R2 data ack");
    send_byte(8'hFF, 1, 1, "R2 data ack");
    check(div_word == 15'h7FFF, "R6 first pair", div_word, 15'h7FFF);
    send_byte(8'h81, 1, 1, "R2 data ack");
    send_byte(8'h02, 1, 1, "R2 data ack");
    send_byte(8'h00, 1, 1, "R2 data ack");
    send_byte(8'h80, 1, 1, "R2 data ack");
    check(div_word == 15'h0080 && ref_code == 1, "R6 third pair", div_word, 15'h0080);
    i2c_stop();

    // R1 address mismatch
    i2c_start();
    send_byte(8'b1100_0010, 0, 0, "R1 wrong pin bits nack");
    send_byte(8'h55, 0, 0, "R1 data after nack ignored");
    i2c_stop();
    i2c_start();
    send_byte(8'b1110_0100, 0, 0, "R1 wrong fixed bits nack");
    i2c_stop();
    check(div_word == 15'h0080, "R1 no change on mismatch", div_word, 15'h0080);

    // R7 stop after high byte
    i2c_start();
    send_byte(AW, 1, 0, "R1 address ack");
    send_byte(8'h55, 1, 1, "R2 data ack");
    i2c_stop();
    check(div_word == 15'h5580, "R7 stop applies high bits", div_word, 15'h5580);

    // R8 stop inside a byte
    i2c_start();
    send_byte(AW, 1, 0, "R1 address ack");
    send_byte(8'hE3, 1, 1, "R2 data ack");
    for (int i = 7; i >= 4; i--) put_bit(1'b1);
    i2c_stop();
    check({test_code, osc_sel, refout_en, port_bit} == 6'b000_0_1_0, "R8 partial byte dropped",
          {test_code, osc_sel, refout_en, port_bit}, 6'b000010);

    // R12 repeated start restarts classification
    i2c_start();
    send_byte(AW, 1, 0, "R1 address ack");
    send_byte(8'h11, 1, 1, "R2 data ack");
    i2c_start();
    send_byte(AW, 1, 0, "R1 address ack");
    send_byte(8'h83, 1, 1, "R2 data ack");
    check(cp_code == 0 && ref_code == 3, "R12 reclassified as control A", {cp_code, ref_code}, 3);
    send_byte(8'h01, 1, 1, "R2 data ack");
    i2c_stop();
    check(div_word == 15'h1180 && port_bit == 1, "R12 pending word on stop", div_word, 15'h1180);

    // R9 R10 status reads
    lock_i = 1;
    i2c_start();
    send_byte(AR, 1, 0, "R1 read address ack");
    recv_byte(1, got); check(got == 8'hC0, "R9 status first", got, 8'hC0);
    recv_byte(0, got); check(got == 8'hC0, "R9 status repeated", got, 8'hC0);
    recv_byte(0, got); check(got == 8'hFF, "R9 silent after nack", got, 8'hFF);
    i2c_stop();
    lock_i = 0;
    i2c_start();
    send_byte(AR, 1, 0, "R1 read address ack");
    recv_byte(0, got); check(got == 8'h00, "R10 por cleared by read stop", got, 8'h00);
    i2c_stop();
    supply_low = 1; tick(3); supply_low = 0; tick(3);
    i2c_start();
    send_byte(AR, 1, 0, "R1 read address ack");
    recv_byte(0, got); check(got == 8'h80, "R10 por set by supply drop", got, 8'h80);
    i2c_stop();

    tick(20);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule